// File: doc/BRIEF.md
# Pulse Accumulator Event Counter

This block is a 16-bit accumulator tied to one external input pin. Software picks one of two ways to use it. In event mode the counter advances once for every chosen transition of the pin. In gated mode the counter advances once every 64 bus clocks for as long as the pin sits at its active level, so the final count measures how long the pin was active. In both modes the selected transition also raises a sticky edge flag, and a wrap of the counter raises a sticky overflow flag. Each flag drives its own interrupt line through a separate enable bit.

The pin is brought into the clock domain by a two-flop synchronizer and then passed to an edge detector. Software reaches the block through a small register port. The control register is at address 0, the status flags at address 1 and the count at address 2. Writes are single-cycle strobes, and reads come back combinationally on `rdData`.

Top module: `evt_accum`

## Requirements
- R1: After reset the count, the control register (address 0) and both flags (address 1) read 0, and both interrupt outputs are low.
- R2: While control bit 0 (enable) is 0, pin activity changes neither the count nor either flag.
- R3: With enable=1, control bit 1 (gated) = 0 and control bit 2 (edge select) = 0, each falling edge of the pin adds one to the count and sets status bit 0 (edge flag). A rising edge does neither. The count shows a pin change two clock edges after the pin has been sampled.
- R4: With enable=1, gated=0 and edge select=1, each rising edge of the pin adds one to the count and sets the edge flag. A falling edge does neither.
- R5: With enable=1, gated=1 and edge select=0, the count advances once every 64 clocks while the pin is high. The 64-clock divider starts from zero at the write that enables the block. A falling edge sets the edge flag, and the count holds while the pin is low.
- R6: With enable=1, gated=1 and edge select=1, the count advances once every 64 clocks while the pin is low, and a rising edge sets the edge flag.
- R7: An increment from 0xFFFF wraps the count to 0x0000 and sets status bit 1 (overflow flag).
- R8: Writing 1 to a status bit clears that flag. Writing 0 leaves the flag unchanged. If a set and a clear land in the same cycle, the set wins.
- R9: A write to address 2 loads the count. It takes priority over an increment in the same cycle.
- R10: `irqEdge` is high exactly when the edge flag and control bit 3 are both 1. `irqOvf` is high exactly when the overflow flag and control bit 4 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pinIn | input | 1 | Asynchronous input pin |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data |
| irqEdge | output | 1 | Edge interrupt request |
| irqOvf | output | 1 | Overflow interrupt request |

## Verification
The assertions check properties that hold on every cycle:
- the count never moves while the block is disabled;
- without a load, the count either holds or steps by exactly one;
- a wrap always sets the overflow flag;
- a count write always lands;
- the edge flag stays set until a 1 is written to it;
- the overflow interrupt never fires without its flag.

Some behaviours can only be shown by the bench's scenarios. These are which edge counts in each mode, the 64-clock gated rate and its phase after enabling, and the priority of a set over a same-cycle clear and of a load over an increment. The bench sweeps all four mode combinations with several pulse counts and several gated durations.

// File: rtl/evt_accum_pkg.sv
package evt_accum_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic ovfIe;
    logic edgeIe;
    logic edgeSel;
    logic gated;
    logic enable;
  } accCtrl_t;

  typedef struct packed {
    logic cntInc;
    logic cntLoad;
    logic edgeSet;
    logic edgeClr;
    logic ovfClr;
  } accStrobes_t;
endpackage

// File: rtl/evt_accum_ctrl.sv
module evt_accum_ctrl
  import evt_accum_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output accCtrl_t          ctrlReg,
  output accStrobes_t       strobes
);
  localparam int DIV_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic pinSync, pinPrev;
  logic riseDet, fallDet, selEdge, activeLvl, tick;
  logic [DIV_W-1:0] divCnt;
  logic wrCtrl, wrStat;

  // synchronizer chain
  always_ff @(posedge clk) begin
    if (rst) syncChain[0] <= 1'b0;
    else     syncChain[0] <= pinIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) syncChain[s] <= 1'b0;
      else     syncChain[s] <= syncChain[s-1];
    end
  end
  assign pinSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) pinPrev <= 1'b0;
    else     pinPrev <= pinSync;
  end

  assign riseDet = pinSync & ~pinPrev;
  assign fallDet = ~pinSync & pinPrev;

  // control register
  assign wrCtrl = wrEn && (addr == ADDR_CTRL);
  assign wrStat = wrEn && (addr == ADDR_STAT);

  always_ff @(posedge clk) begin
    if (rst)         ctrlReg <= '0;
    else if (wrCtrl) ctrlReg <= accCtrl_t'(wrData[CTRL_W-1:0]);
  end

  // divide-by-PRESCALE time base, held at zero while disabled
  always_ff @(posedge clk) begin
    if (rst || !ctrlReg.enable) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                         divCnt <= divCnt + 1'b1;
  end
  assign tick = ctrlReg.enable && (divCnt == DIV_LAST);

  assign selEdge   = ctrlReg.edgeSel ? riseDet : fallDet;
  assign activeLvl = pinSync ^ ctrlReg.edgeSel;

  always_comb begin
    strobes.cntInc  = ctrlReg.enable &&
                      (ctrlReg.gated ? (tick && activeLvl) : selEdge);
    strobes.cntLoad = wrEn && (addr == ADDR_CNT);
    strobes.edgeSet = ctrlReg.enable && selEdge;
    strobes.edgeClr = wrStat && wrData[0];
    strobes.ovfClr  = wrStat && wrData[1];
  end
endmodule

// File: rtl/evt_accum_dp.sv
module evt_accum_dp
  import evt_accum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  accStrobes_t      strobes,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             edgeFlag,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic wrapNow;

  assign wrapNow = strobes.cntInc && !strobes.cntLoad && (cntVal == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst)                  cntVal <= '0;
    else if (strobes.cntLoad) cntVal <= loadVal;
    else if (strobes.cntInc)  cntVal <= cntVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                  edgeFlag <= 1'b0;
    else if (strobes.edgeSet) edgeFlag <= 1'b1;
    else if (strobes.edgeClr) edgeFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)                 ovfFlag <= 1'b0;
    else if (wrapNow)        ovfFlag <= 1'b1;
    else if (strobes.ovfClr) ovfFlag <= 1'b0;
  end
endmodule

// File: rtl/evt_accum.sv
module evt_accum
  import evt_accum_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESCALE    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pinIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irqEdge,
  output logic              irqOvf
);
  accCtrl_t         ctrlReg;
  accStrobes_t      strobes;
  logic [CNT_W-1:0] cntVal;
  logic             edgeFlag, ovfFlag;

  evt_accum_ctrl #(
    .DATA_W(CNT_W), .PRESCALE(PRESCALE), .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk(clk), .rst(rst), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .ctrlReg(ctrlReg), .strobes(strobes)
  );

  evt_accum_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .loadVal(wrData),
    .cntVal(cntVal), .edgeFlag(edgeFlag), .ovfFlag(ovfFlag)
  );

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdData = CNT_W'(ctrlReg);
      ADDR_STAT: rdData = CNT_W'({ovfFlag, edgeFlag});
      ADDR_CNT:  rdData = cntVal;
      default:   rdData = '0;
    endcase
  end

  assign irqEdge = edgeFlag & ctrlReg.edgeIe;
  assign irqOvf  = ovfFlag & ctrlReg.ovfIe;
endmodule

// File: rtl/evt_accum_chk.sv
module evt_accum_chk
  import evt_accum_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wrData,
  input logic [CNT_W-1:0]  count,
  input logic              enable,
  input logic              cntInc,
  input logic              edgeFlag,
  input logic              ovfFlag,
  input logic              irqOvf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic loadW, edgeClrW;
  assign loadW    = wrEn && (addr == ADDR_CNT);
  assign edgeClrW = wrEn && (addr == ADDR_STAT) && wrData[0];

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!enable && !loadW) |=> $stable(count));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    !loadW |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

  assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    (!loadW && cntInc && count == CNT_MAX) |=> (ovfFlag && count == '0));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (edgeFlag && !edgeClrW) |=> edgeFlag);

  assert_load_lands_R9: assert property (@(posedge clk) disable iff (rst)
    loadW |=> (count == $past(wrData)));

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (rst)
    irqOvf |-> ovfFlag);
endmodule

bind evt_accum evt_accum_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .count(cntVal), .enable(ctrlReg.enable), .cntInc(strobes.cntInc),
  .edgeFlag(edgeFlag), .ovfFlag(ovfFlag), .irqOvf(irqOvf)
);

// File: tb/test_evt_accum.sv
`timescale 1ns/1ps
module test_evt_accum;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pinIn = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic irqEdge, irqOvf;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  evt_accum i_evt_accum (
    .clk(clk), .rst(rst), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqEdge(irqEdge), .irqOvf(irqOvf)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic setPin(input logic v);
    @(negedge clk);
    pinIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input logic [15:0] ctrl, input logic idle);
    wr(2'd0, 16'h0000);
    wr(2'd2, 16'h0000);
    wr(2'd1, 16'h0003);
    setPin(idle);
    wr(2'd0, ctrl);
  endtask

  logic [15:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
    rd(2'd1, v); chk("R1 status", v, 16'h0);
    rd(2'd2, v); chk("R1 count", v, 16'h0);
    chk("R1 irqs", {14'b0, irqEdge, irqOvf}, 16'h0);

    // R3/R4 event mode sweep
    for (int es = 0; es < 2; es++) begin
      for (int n = 1; n <= 5; n += 2) begin
        setup(16'h0001 | 16'(es << 2), 1'b0);
        setPin(1'b1);
        rd(2'd2, v); chk(es ? "R4 rise count" : "R3 rise ignored", v, 16'(es));
        rd(2'd1, v); chk(es ? "R4 rise flag" : "R3 rise no flag", v, 16'(es));
        setPin(1'b0);
        rd(2'd2, v); chk(es ? "R4 fall ignored" : "R3 fall count", v, 16'h1);
        rd(2'd1, v); chk(es ? "R4 flag kept" : "R3 fall flag", v, 16'h1);
        for (int p = 1; p < n; p++) begin
          setPin(1'b1);
          setPin(1'b0);
        end
        rd(2'd2, v); chk(es ? "R4 pulses" : "R3 pulses", v, 16'(n));
      end
    end

    // R5/R6 gated mode sweep
    for (int es = 0; es < 2; es++) begin
      setup(16'h0000, es ? 1'b0 : 1'b1);
      wr(2'd0, 16'h0003 | 16'(es << 2));
      for (int k = 1; k <= 3; k++) begin
        repeat ((k == 1) ? 96 : 64) @(negedge clk);
        rd(2'd2, v); chk(es ? "R6 gated low count" : "R5 gated high count", v, 16'(k));
      end
      rd(2'd1, v); chk(es ? "R6 no flag yet" : "R5 no flag yet", v, 16'h0);
      setPin(es ? 1'b1 : 1'b0);
      rd(2'd1, v); chk(es ? "R6 rise flag" : "R5 fall flag", v, 16'h1);
      repeat (200) @(negedge clk);
      rd(2'd2, v); chk(es ? "R6 hold inactive" : "R5 hold inactive", v, 16'h3);
    end

    // R2 disabled: mode bits set but enable clear
    setup(16'h0000, 1'b0);
    wr(2'd2, 16'h0042);
    wr(2'd0, 16'h0004);
    for (int p = 0; p < 3; p++) begin
      setPin(1'b1);
      setPin(1'b0);
    end
    rd(2'd2, v); chk("R2 count frozen", v, 16'h0042);
    rd(2'd1, v); chk("R2 no flags", v, 16'h0);

    // R7 overflow and R10 overflow interrupt
    setup(16'h0015, 1'b0);
    wr(2'd2, 16'hFFFE);
    setPin(1'b1); setPin(1'b0);
    rd(2'd2, v); chk("R7 count ffff", v, 16'hFFFF);
    rd(2'd1, v); chk("R7 no ovf yet", v, 16'h1);
    chk("R10 irqOvf low", {15'b0, irqOvf}, 16'h0);
    setPin(1'b1); setPin(1'b0);
    rd(2'd2, v); chk("R7 wrap", v, 16'h0000);
    rd(2'd1, v); chk("R7 ovf flag", v, 16'h3);
    chk("R10 irqOvf high", {15'b0, irqOvf}, 16'h1);
    // R8 write-one-to-clear, bit by bit
    wr(2'd1, 16'h0002);
    rd(2'd1, v); chk("R8 clear ovf only", v, 16'h1);
    chk("R10 irqOvf cleared", {15'b0, irqOvf}, 16'h0);
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R8 write zero no effect", v, 16'h1);
    // R10 edge interrupt gated by control bit 3
    chk("R10 irqEdge masked", {15'b0, irqEdge}, 16'h0);
    wr(2'd0, 16'h000D);
    chk("R10 irqEdge armed", {15'b0, irqEdge}, 16'h1);
    wr(2'd1, 16'h0001);
    chk("R10 irqEdge after clear", {15'b0, irqEdge}, 16'h0);

    // R9 load beats same-cycle increment (rising mode)
    setup(16'h0005, 1'b0);
    @(negedge clk); pinIn = 1'b1;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 2'd2; wrData = 16'd100;
    @(negedge clk); wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R9 load wins", v, 16'd100);

    // R8 set beats same-cycle clear
    setPin(1'b0);
    wr(2'd1, 16'h0003);
    rd(2'd1, v); chk("R8 flag cleared", v, 16'h0);
    @(negedge clk); pinIn = 1'b1;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b1; addr = 2'd1; wrData = 16'h0001;
    @(negedge clk); wrEn = 1'b0;
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R8 set wins", v, 16'h1);
    rd(2'd2, v); chk("R9 increment after load", v, 16'd101);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule